// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Bit

This block serialises bytes onto an asynchronous line. Each character is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Bit timing comes from an oversampling enable (`os_tick`) that pulses at 8, 16 or 32 times the bit rate. Every start and data bit lasts exactly the oversampling factor in ticks. The stop bit can be cut short to a programmed number of ticks, which lets a sender run slightly faster than the far end. The stop length is set by a 4-bit code whose meaning depends on the oversampling mode.

A clear-to-send input gates the start of each character. If clear-to-send drops while a character is on the line, that character still finishes with normal timing. The channel then halts, raises a sticky loss flag and, unless masked, an interrupt. It stays halted until a restart pulse has been seen and clear-to-send is high again.

Top module: `uart_fstop_tx`

## Requirements
- R1: After reset the line is high, `cts_lost` and `irq` are 0, and the stop code register holds 4'b1111. The first character after reset therefore has a full-length stop bit.
- R2: After a byte is accepted, the line goes low for one bit time of start. The eight data bits follow LSB first, then the line goes high for the stop bit. Each start and data bit lasts the oversampling factor in `os_tick` pulses. The line is high whenever `tx_ready` is high.
- R3: With `os_mode`=2'b01 (16x), codes 4'b1000 to 4'b1111 give a stop bit of code+1 ticks. For example, 1111 gives 16 and 1000 gives 9.
- R4: With `os_mode`=2'b10 (32x), every code is legal and gives code+17 ticks. For example, 1111 gives 32 and 0000 gives 17.
- R5: With `os_mode`=2'b00 (8x), codes 4'b1100 to 4'b1111 give code-7 ticks, that is 5, 6, 7 or 8.
- R6: A stop code that is illegal for the mode gives a full stop bit, and `cfg_illegal` is high while the pair is selected. The illegal codes are 0xxx at 16x and 0xxx or 10xx at 8x. `os_mode`=2'b11 is treated as 16x timing with `cfg_illegal` high.
- R7: `tx_ready` is high only when the channel is idle, not halted, and `cts` is high. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` rises on the cycle after the stop bit's last tick.
- R8: While idle with `cts` low, no character starts, the line stays high and `cts_lost` stays 0.
- R9: If `cts` goes low during a character, the character completes with unchanged timing. `cts_lost` then rises on the cycle after the stop bit's last tick, and the channel halts with `tx_ready` low.
- R10: `irq` is high exactly when `cts_lost` is high and `irq_mask` is 0.
- R11: A halted channel returns to idle only after a `restart` pulse has been seen while halted, with `cts` high at that point or later. A `restart` pulse outside the halted state has no effect.
- R12: A pulse on `cts_lost_clr` clears `cts_lost` on the next cycle. A new loss event in the same cycle takes priority and sets the flag.
- R13: Cycles where `os_tick` is low do not advance the character. The line holds its value and the character's end moves later by the number of missing ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, one pulse per sub-bit tick |
| os_mode | input | 2 | Oversampling select: 00 8x, 01 16x, 10 32x, 11 reserved |
| fstop_wr | input | 1 | Write strobe for the stop code register |
| fstop_wdata | input | 4 | New stop code |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte is offered |
| tx_ready | output | 1 | Byte can be taken this cycle |
| cts | input | 1 | Clear-to-send, active high |
| restart | input | 1 | Restart pulse after a loss halt |
| irq_mask | input | 1 | Masks the interrupt when high |
| cts_lost_clr | input | 1 | Clears the loss flag |
| cts_lost | output | 1 | Sticky clear-to-send loss flag |
| irq | output | 1 | Transmit interrupt |
| cfg_illegal | output | 1 | Stop code is illegal for the selected mode |
| txd | output | 1 | Serial line, idles high |

## Verification
Cycles are counted from the edge that accepts a byte, with `os_tick` held high. With factor F and stop length S, the line is low from that edge for F cycles, and data bit i occupies cycles F(1+i) to F(2+i)-1. `tx_ready` and the loss flag change exactly F·9+S cycles after acceptance, plus any cycles where the tick was withheld. The bench samples on the falling edge, with k counting falling edges since acceptance. It reads each data bit in the middle of its window, and reads the ready and flag outputs exactly at k = 9F+S and at k = 9F+S-1. A one-cycle shift in the stop length or in the halt timing therefore shows up as a miscompare. Register writes, clears and restarts are checked on the first falling edge after the rising edge that captures them.

// File: rtl/uft_pkg.sv
// Shared types for the fractional-stop transmitter.
// Assumes: mode encodings are fixed by the port contract of uart_fstop_tx.
package uft_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HALT
    } tx_state_e;

    localparam logic [1:0] OSR_8X  = 2'b00;
    localparam logic [1:0] OSR_16X = 2'b01;
    localparam logic [1:0] OSR_32X = 2'b10;
endpackage

// File: rtl/uft_stop_calc.sv
// Maps oversampling mode and stop code to tick counts for a data bit and
// for the stop bit, and flags a code that the mode does not allow.
// Assumes: FS_W is 4 and CNT_W can hold the largest oversampling factor.
module uft_stop_calc #(
    parameter int FS_W  = 4,
    parameter int CNT_W = 6
) (
    input  logic [1:0]       mode,
    input  logic [FS_W-1:0]  code,
    output logic [CNT_W-1:0] bit_ticks,
    output logic [CNT_W-1:0] stop_ticks,
    output logic             illegal
);
    import uft_pkg::*;

    localparam logic [CNT_W-1:0] T8  = CNT_W'(8);
    localparam logic [CNT_W-1:0] T16 = CNT_W'(16);
    localparam logic [CNT_W-1:0] T32 = CNT_W'(32);

    logic [CNT_W-1:0] code_w;
    assign code_w = CNT_W'(code);

    // Decode tick counts per mode; illegal codes fall back to a full bit.
    always_comb begin
        illegal    = 1'b0;
        bit_ticks  = T16;
        stop_ticks = T16;
        unique case (mode)
            OSR_8X: begin
                bit_ticks = T8;
                if (code[FS_W-1:FS_W-2] == 2'b11) begin
                    stop_ticks = code_w - CNT_W'(7);
                end else begin
                    stop_ticks = T8;
                    illegal    = 1'b1;
                end
            end
            OSR_16X: begin
                bit_ticks = T16;
                if (code[FS_W-1]) begin
                    stop_ticks = code_w + CNT_W'(1);
                end else begin
                    stop_ticks = T16;
                    illegal    = 1'b1;
                end
            end
            OSR_32X: begin
                bit_ticks  = T32;
                stop_ticks = code_w + CNT_W'(17);
            end
            default: begin
                bit_ticks  = T16;
                stop_ticks = T16;
                illegal    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/uft_cfg_reg.sv
// Holds the stop code; resets to all ones, which is a full stop bit in
// every mode.
// Assumes: writes happen only while the channel is idle or halted.
module uft_cfg_reg #(
    parameter int FS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [FS_W-1:0] wdata,
    output logic [FS_W-1:0] code
);
    // Capture a new stop code on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '1;
        end else if (wr) begin
            code <= wdata;
        end
    end
endmodule

// File: rtl/uft_flow.sv
// Clear-to-send loss bookkeeping: sticky loss flag, masked interrupt,
// and the restart handshake that lets a halted core resume.
// Assumes: halt_evt is a one-cycle pulse from the core at halt entry.
module uft_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_evt,
    input  logic halted,
    input  logic restart,
    input  logic cts,
    input  logic clr,
    input  logic irq_mask,
    output logic resume,
    output logic cts_lost,
    output logic irq
);
    logic rs_pend;

    assign resume = halted && cts && (restart || rs_pend);
    assign irq    = cts_lost && !irq_mask;

    // Loss flag: set on halt entry, clear on request; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_lost <= 1'b0;
        end else if (halt_evt) begin
            cts_lost <= 1'b1;
        end else if (clr) begin
            cts_lost <= 1'b0;
        end
    end

    // Remember a restart seen while halted until the line is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_pend <= 1'b0;
        end else if (!halted || resume) begin
            rs_pend <= 1'b0;
        end else if (restart) begin
            rs_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/uft_tx_core.sv
// Character sequencer and shifter: start, data LSB first, shortened stop.
// Tick lengths are latched when a byte is accepted, so configuration
// changes during a character do not disturb it.
// Assumes: bit_ticks and stop_ticks are non-zero.
module uft_tx_core #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              cts,
    input  logic [CNT_W-1:0]  bit_ticks,
    input  logic [CNT_W-1:0]  stop_ticks,
    input  logic              resume,
    output logic              tx_ready,
    output logic              txd,
    output logic              halt_evt,
    output logic              halted
);
    import uft_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [CNT_W-1:0]  bit_len;
    logic [CNT_W-1:0]  stop_len;
    logic [CNT_W-1:0]  cur_len;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              lost_pend;
    logic              last_tick;
    logic              accept;
    logic              busy;

    assign tx_ready  = (state == ST_IDLE) && cts;
    assign accept    = tx_valid && tx_ready;
    assign busy      = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
    assign cur_len   = (state == ST_STOP) ? stop_len : bit_len;
    assign last_tick = os_tick && (tick_cnt == cur_len - CNT_W'(1));
    assign halt_evt  = (state == ST_STOP) && last_tick && (lost_pend || !cts);
    assign halted    = (state == ST_HALT);

    // Sequence the character and drive the registered line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tick_cnt  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            bit_len   <= CNT_W'(16);
            stop_len  <= CNT_W'(16);
            lost_pend <= 1'b0;
            txd       <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_START;
                        shreg     <= tx_data;
                        bit_len   <= bit_ticks;
                        stop_len  <= stop_ticks;
                        tick_cnt  <= '0;
                        bit_idx   <= '0;
                        lost_pend <= 1'b0;
                        txd       <= 1'b0;
                    end
                end
                ST_START, ST_DATA, ST_STOP: begin
                    if (!cts) begin
                        lost_pend <= 1'b1;
                    end
                    if (os_tick) begin
                        if (!last_tick) begin
                            tick_cnt <= tick_cnt + CNT_W'(1);
                        end else begin
                            tick_cnt <= '0;
                            if (state == ST_START) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                txd     <= shreg[0];
                            end else if (state == ST_DATA) begin
                                if (bit_idx == LAST_IDX) begin
                                    state <= ST_STOP;
                                    txd   <= 1'b1;
                                end else begin
                                    bit_idx <= bit_idx + IDX_W'(1);
                                    shreg   <= shreg >> 1;
                                    txd     <= shreg[1];
                                end
                            end else begin
                                state <= halt_evt ? ST_HALT : ST_IDLE;
                                txd   <= 1'b1;
                            end
                        end
                    end
                end
                ST_HALT: begin
                    txd <= 1'b1;
                    if (resume) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    txd   <= 1'b1;
                end
            endcase
        end
    end

    // Busy is only used to document the character window for reviewers.
    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: rtl/uart_fstop_tx.sv
// Top level: asynchronous transmitter with a programmable shortened stop
// bit and halt-on-clear-to-send-loss. Wires the code register, the tick
// decoder, the character core and the flow logic together.
// Assumes: os_tick is synchronous to clk; os_mode is held while busy.
module uart_fstop_tx #(
    parameter int DATA_W  = 8,
    parameter int FS_W    = 4,
    parameter int MAX_OSR = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [1:0]        os_mode,
    input  logic              fstop_wr,
    input  logic [FS_W-1:0]   fstop_wdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              cts,
    input  logic              restart,
    input  logic              irq_mask,
    input  logic              cts_lost_clr,
    output logic              cts_lost,
    output logic              irq,
    output logic              cfg_illegal,
    output logic              txd
);
    localparam int CNT_W = $clog2(MAX_OSR + 1);

    logic [FS_W-1:0]  code;
    logic [CNT_W-1:0] bit_ticks;
    logic [CNT_W-1:0] stop_ticks;
    logic             halt_evt;
    logic             halted;
    logic             resume;

    uft_cfg_reg #(.FS_W(FS_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fstop_wr),
        .wdata (fstop_wdata),
        .code  (code)
    );

    uft_stop_calc #(.FS_W(FS_W), .CNT_W(CNT_W)) u_calc (
        .mode       (os_mode),
        .code       (code),
        .bit_ticks  (bit_ticks),
        .stop_ticks (stop_ticks),
        .illegal    (cfg_illegal)
    );

    uft_tx_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .cts        (cts),
        .bit_ticks  (bit_ticks),
        .stop_ticks (stop_ticks),
        .resume     (resume),
        .tx_ready   (tx_ready),
        .txd        (txd),
        .halt_evt   (halt_evt),
        .halted     (halted)
    );

    uft_flow u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_evt (halt_evt),
        .halted   (halted),
        .restart  (restart),
        .cts      (cts),
        .clr      (cts_lost_clr),
        .irq_mask (irq_mask),
        .resume   (resume),
        .cts_lost (cts_lost),
        .irq      (irq)
    );
endmodule

// File: rtl/uft_chk.sv
// Port-level properties of uart_fstop_tx, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module uft_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic cts_lost,
    input logic cts_lost_clr,
    input logic irq,
    input logic irq_mask
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd); // R7

    AST_HALT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_lost) |-> !tx_ready); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cts_lost && !irq_mask)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cts_lost |=> (cts_lost || $past(cts_lost_clr))); // R12

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_tick && !(tx_valid && tx_ready)) |=> $stable(txd)); // R13
endmodule

bind uart_fstop_tx uft_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .txd          (txd),
    .cts_lost     (cts_lost),
    .cts_lost_clr (cts_lost_clr),
    .irq          (irq),
    .irq_mask     (irq_mask)
);

// File: tb/uart_fstop_tx_tb.sv
`timescale 1ns/1ps
module uart_fstop_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic [1:0] os_mode = 2'b01;
    logic       fstop_wr = 1'b0;
    logic [3:0] fstop_wdata = 4'hF;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       cts = 1'b1;
    logic       restart = 1'b0;
    logic       irq_mask = 1'b0;
    logic       cts_lost_clr = 1'b0;
    logic       cts_lost;
    logic       irq;
    logic       cfg_illegal;
    logic       txd;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    uart_fstop_tx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
        .fstop_wr(fstop_wr), .fstop_wdata(fstop_wdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .cts(cts), .restart(restart),
        .irq_mask(irq_mask), .cts_lost_clr(cts_lost_clr), .cts_lost(cts_lost),
        .irq(irq), .cfg_illegal(cfg_illegal), .txd(txd)
    );

    function automatic int osr_of(input logic [1:0] m);
        return (m == 2'b00) ? 8 : (m == 2'b10) ? 32 : 16;
    endfunction

    function automatic bit exp_illegal(input logic [1:0] m, input logic [3:0] c);
        if (m == 2'b00) return c[3:2] != 2'b11;
        if (m == 2'b01) return !c[3];
        if (m == 2'b10) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_stop(input logic [1:0] m, input logic [3:0] c);
        if (exp_illegal(m, c)) return osr_of(m);
        if (m == 2'b00) return int'(c) - 7;
        if (m == 2'b01) return int'(c) + 1;
        return int'(c) + 17;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] c);
        os_mode = m;
        fstop_wdata = c;
        fstop_wr = 1'b1;
        @(negedge clk);
        fstop_wr = 1'b0;
    endtask

    // Send one byte; k counts falling edges after the accepting edge.
    task automatic xfer(input logic [7:0] d, input int osr, input int stp,
                        input int drop_k, input int fz, input int clr_k,
                        output int rdy_k, output logic [7:0] got,
                        output logic lost_pre, output logic lost_at,
                        output logic start_ok, output logic stop_ok);
        int lim;
        int endk;
        endk = 9 * osr + stp + fz;
        lim = endk + 3;
        rdy_k = -1; got = 8'h00; lost_pre = 1'b0; lost_at = 1'b0;
        start_ok = 1'b0; stop_ok = 1'b0;
        tx_data = d;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k <= lim; k++) begin
            if (k == drop_k) cts = 1'b0;
            if (fz > 0 && k == 2) os_tick = 1'b0;
            if (fz > 0 && k == 2 + fz) os_tick = 1'b1;
            cts_lost_clr = (k == clr_k);
            if (k == 1) start_ok = (txd == 1'b0);
            for (int i = 0; i < 8; i++)
                if (k == osr * (1 + i) + osr / 2 + fz) got[i] = txd;
            if (k == 9 * osr + fz) stop_ok = (txd == 1'b1);
            if (k == endk - 1) lost_pre = cts_lost;
            if (k == endk) lost_at = cts_lost;
            if (tx_ready && rdy_k < 0) rdy_k = k;
            @(negedge clk);
        end
        cts_lost_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int rk;
        logic [7:0] g;
        logic lp, la, so, po;
        int seed;
        seed = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(cts_lost == 1'b0 && irq == 1'b0, "R1 flags", cts_lost, 0);
        chk(tx_ready == 1'b1, "R7 ready idle", tx_ready, 1);
        chk(cfg_illegal == 1'b0, "R1 cfg", cfg_illegal, 0);
        // R1: first character uses full stop (16x, code reset 1111)
        xfer(8'hA5, 16, 16, -1, 0, -1, rk, g, lp, la, so, po);
        chk(g == 8'hA5, "R2 data", g, 8'hA5);
        chk(so && po, "R2 start/stop", {so, po}, 3);
        chk(rk == 9 * 16 + 16, "R1 full stop", rk, 9 * 16 + 16);

        // R3 R4 R5: directed extremes
        set_cfg(2'b01, 4'b1000);
        xfer(8'h3C, 16, 9, -1, 0, -1, rk, g, lp, la, so, po);
        chk(rk == 144 + 9, "R3 16x 1000", rk, 153);
        set_cfg(2'b10, 4'b0000);
        xfer(8'h81, 32, 17, -1, 0, -1, rk, g, lp, la, so, po);
        chk(rk == 288 + 17 && g == 8'h81, "R4 32x 0000", rk, 305);
        set_cfg(2'b00, 4'b1100);
        xfer(8'h01, 8, 5, -1, 0, -1, rk, g, lp, la, so, po);
        chk(rk == 72 + 5 && g == 8'h01, "R5 8x 1100", rk, 77);

        // R6: illegal codes fall back to full stop
        set_cfg(2'b00, 4'b1011);
        chk(cfg_illegal == 1'b1, "R6 flag 8x", cfg_illegal, 1);
        xfer(8'hF0, 8, 8, -1, 0, -1, rk, g, lp, la, so, po);
        chk(rk == 80, "R6 8x full", rk, 80);
        set_cfg(2'b11, 4'b1111);
        chk(cfg_illegal == 1'b1, "R6 flag mode3", cfg_illegal, 1);
        xfer(8'h5A, 16, 16, -1, 0, -1, rk, g, lp, la, so, po);
        chk(rk == 160 && g == 8'h5A, "R6 mode3 16x", rk, 160);

        // R13: withheld ticks stretch the character
        set_cfg(2'b01, 4'b1111);
        xfer(8'hC3, 16, 16, -1, 20, -1, rk, g, lp, la, so, po);
        chk(rk == 160 + 20 && g == 8'hC3, "R13 freeze", rk, 180);

        // R8: cts low in idle blocks start, no flag
        cts = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R8 ready", tx_ready, 0);
        tx_valid = 1'b1;
        begin
            int low = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (txd == 1'b0) low++;
            end
            tx_valid = 1'b0;
            chk(low == 0 && cts_lost == 1'b0, "R8 no start", low, 0);
        end
        cts = 1'b1;
        @(negedge clk);

        // R11: restart while not halted is ignored
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        // R9: cts lost mid character
        xfer(8'h96, 16, 16, 40, 0, -1, rk, g, lp, la, so, po);
        chk(g == 8'h96 && rk == -1, "R9 completes then halts", rk, -1);
        chk(lp == 1'b0 && la == 1'b1, "R9 flag timing", {lp, la}, 1);
        chk(irq == 1'b1, "R10 irq", irq, 1);
        irq_mask = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R10 masked", irq, 0);
        irq_mask = 1'b0;
        cts = 1'b1;
        repeat (40) @(negedge clk);
        chk(tx_ready == 1'b0, "R11 no stale restart", tx_ready, 0);
        cts = 1'b0;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (5) @(negedge clk);
        chk(tx_ready == 1'b0, "R11 waits cts", tx_ready, 0);
        cts = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R11 resume", tx_ready, 1);
        // R12: clear
        cts_lost_clr = 1'b1;
        @(negedge clk);
        cts_lost_clr = 1'b0;
        chk(cts_lost == 1'b0 && irq == 1'b0, "R12 clear", cts_lost, 0);

        // R12: set beats clear in the same cycle
        xfer(8'h11, 16, 16, 20, 0, 159, rk, g, lp, la, so, po);
        chk(la == 1'b1, "R12 set priority", la, 1);
        cts = 1'b1;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        cts_lost_clr = 1'b1;
        @(negedge clk);
        cts_lost_clr = 1'b0;
        chk(tx_ready == 1'b1 && cts_lost == 1'b0, "R11 R12 recover", tx_ready, 1);

        // R2 R3 R4 R5 R6: random legal and illegal configurations
        for (int n = 0; n < 24; n++) begin
            logic [1:0] m;
            logic [3:0] c;
            logic [7:0] d;
            int o;
            int s;
            m = 2'($urandom_range(0, 3));
            c = 4'($urandom_range(0, 15));
            d = 8'($urandom_range(0, 255));
            o = osr_of(m);
            s = exp_stop(m, c);
            set_cfg(m, c);
            chk(cfg_illegal == exp_illegal(m, c), "R6 random flag", cfg_illegal, exp_illegal(m, c));
            xfer(d, o, s, -1, 0, -1, rk, g, lp, la, so, po);
            chk(g == d && so && po, "R2 random frame", g, d);
            chk(rk == 9 * o + s, "R3 R4 R5 random stop", rk, 9 * o + s);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule